// File: doc/BRIEF.md
# Virtual-Channel Router Input Port Controller

This block is one input port of a virtual-channel router. Flits come in tagged with a kind (head, body or tail) and the number of the local virtual channel they belong to. Each local VC has a small FIFO and a control sequencer.

A packet's leading flit goes through four steps:
- an XY route lookup on the destination coordinates it carries;
- a request to an external VC allocator for a downstream channel on the chosen output;
- a request to an external switch allocator;
- a registered switch-traversal stage.

Every later flit of the same packet reuses the latched route and downstream channel. These flits go straight to switch allocation.

The port gives a downstream channel back by pulsing a release strobe when a tail flit leaves. Every departing flit carries the downstream channel number, so neighbouring routers need no extra exchange to agree on it.

Both allocators answer within the same cycle as the request. One round-robin picker per allocator chooses which local VC presents a request each cycle. A flit that loses switch allocation keeps its place and asks again. Flits queued behind it in the same VC wait.

Top module: `vcr_input_port`

## Requirements
- R1: With both allocators granting, a head flit accepted at clock edge k appears on the traversal outputs after edge k+4 (route, VC allocation, switch allocation, traversal).
- R2: Body and tail flits of a packet whose channel is already allocated skip routing and VC allocation. Consecutive flits leave on consecutive cycles.
- R3: While a VC waits for VC allocation, `va_req` stays high with `va_port` equal to the computed route and no flit of that VC departs. After a grant, the head leaves two edges later.
- R4: Output ports are encoded 0 local, 1 east (+x), 2 west, 3 north (+y), 4 south. Destination x is `in_data[COORD_W-1:0]` and y is `in_data[2*COORD_W-1:COORD_W]`. X is resolved before Y, and local is chosen when both match the port position.
- R5: A flit denied by the switch allocator stays at its VC front and requests again with the same port. No flit of that VC departs until it is granted.
- R6: Every departing flit of a packet carries the route and the downstream VC granted to its head.
- R7: `rel_valid` pulses, with `rel_port` and `rel_vc` naming the channel, in the same cycle a tail flit is on the traversal outputs, and at no other time.
- R8: A head queued behind the previous packet's tail in the same VC starts routing only after that tail leaves. It departs four cycles after the tail.
- R9: A tail flit (code 11) reaching an idle VC is a single-flit packet. It takes the full four-stage path and releases its channel on departure.
- R10: A body flit (code 10) reaching the front of an idle VC is dropped without output, and the next packet proceeds normally.
- R11: Kind code 00 writes nothing into any VC.
- R12: `vc_full[v]` is high exactly when VC v holds BUF_DEPTH flits.
- R13: A VC stalled in switch allocation does not stop another VC's packet from departing.
- R14: During and after reset, all request, traversal and full outputs are low and queued flits are discarded. Reset is applied asynchronously and released through two flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_type | input | 2 | Flit kind: 00 idle, 01 head, 10 body, 11 tail |
| in_vc | input | $clog2(NUM_VC) | Local VC of the incoming flit |
| in_data | input | DATA_W | Flit payload; head carries destination coordinates |
| vc_full | output | NUM_VC | Per-VC buffer full flag |
| va_req | output | 1 | VC allocation request |
| va_port | output | 3 | Output port the request is for |
| va_gnt | input | 1 | VC allocation grant (same cycle) |
| va_gnt_vc | input | $clog2(NUM_DVC) | Granted downstream VC |
| sa_req | output | 1 | Switch allocation request |
| sa_port | output | 3 | Output port requested |
| sa_gnt | input | 1 | Switch allocation grant (same cycle) |
| st_valid | output | 1 | Flit on traversal outputs |
| st_type | output | 2 | Kind of the departing flit |
| st_port | output | 3 | Output port of the departing flit |
| st_vc | output | $clog2(NUM_DVC) | Downstream VC stamped on the flit |
| st_data | output | DATA_W | Payload of the departing flit |
| rel_valid | output | 1 | Downstream VC release strobe |
| rel_port | output | 3 | Output port of the released VC |
| rel_vc | output | $clog2(NUM_DVC) | Released downstream VC |

## Verification
The bench builds the port with four local VCs of depth four, four downstream VCs, 3-bit coordinates and the router placed at (2,5). That placement has destinations on both sides in x and in y, so a table of destinations can reach all five output codes. Depth four lets one four-flit packet fill a VC while the switch is withheld, which exposes the full flag. Four VCs let one VC stall on a blocked port while another packet passes.

// File: rtl/vcr_pkg.sv
package vcr_pkg;

  typedef enum logic [1:0] {
    FT_IDLE = 2'b00,
    FT_HEAD = 2'b01,
    FT_BODY = 2'b10,
    FT_TAIL = 2'b11
  } flit_kind_e;

  typedef enum logic [1:0] {
    VS_IDLE,
    VS_ROUTE,
    VS_VCALLOC,
    VS_SWALLOC
  } vc_stage_e;

  localparam logic [2:0] OP_LOCAL = 3'd0;
  localparam logic [2:0] OP_EAST  = 3'd1;
  localparam logic [2:0] OP_WEST  = 3'd2;
  localparam logic [2:0] OP_NORTH = 3'd3;
  localparam logic [2:0] OP_SOUTH = 3'd4;

endpackage

// File: rtl/vcr_flit_fifo.sv
module vcr_flit_fifo #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_nxt;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (int'(p) == DEPTH - 1) return '0;
    return p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_nxt = wr_ptr_q;
    rd_ptr_nxt = rd_ptr_q;
    cnt_nxt    = cnt_q;
    if (push) wr_ptr_nxt = ptr_inc(wr_ptr_q);
    if (pop)  rd_ptr_nxt = ptr_inc(rd_ptr_q);
    if (push && !pop) cnt_nxt = cnt_q + 1'b1;
    else if (pop && !push) cnt_nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_nxt;
      rd_ptr_q <= rd_ptr_nxt;
      cnt_q    <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= push_data;
  end

  assign head  = mem[rd_ptr_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));

  // R12: storage never written beyond its depth
  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |-> pop);

  p_no_underflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/vcr_route_xy.sv
module vcr_route_xy
  import vcr_pkg::*;
#(
  parameter int COORD_W = 3,
  parameter int X_POS   = 1,
  parameter int Y_POS   = 1
) (
  input  logic [2*COORD_W-1:0] dest,
  output logic [2:0]           port
);

  localparam logic [COORD_W-1:0] HERE_X = COORD_W'(X_POS);
  localparam logic [COORD_W-1:0] HERE_Y = COORD_W'(Y_POS);

  logic [COORD_W-1:0] dx, dy;

  assign dx = dest[COORD_W-1:0];
  assign dy = dest[2*COORD_W-1:COORD_W];

  always_comb begin
    if (dx > HERE_X)      port = OP_EAST;
    else if (dx < HERE_X) port = OP_WEST;
    else if (dy > HERE_Y) port = OP_NORTH;
    else if (dy < HERE_Y) port = OP_SOUTH;
    else                  port = OP_LOCAL;
  end

endmodule

// File: rtl/vcr_rr_arb.sv
module vcr_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q, ptr_nxt, win, idx;
  logic          found;

  always_comb begin
    gnt   = '0;
    win   = ptr_q;
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      idx = IW'((int'(ptr_q) + i) % N);
      if (!found && req[idx]) begin
        found    = 1'b1;
        gnt[idx] = 1'b1;
        win      = idx;
      end
    end
    ptr_nxt = ptr_q;
    if (found) begin
      if (int'(win) == N - 1) ptr_nxt = '0;
      else                    ptr_nxt = win + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_nxt;
  end

  // R13: at most one requester picked, and only a requester
  p_pick_legal_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == '0));

endmodule

// File: rtl/vcr_vc_ctrl.sv
module vcr_vc_ctrl
  import vcr_pkg::*;
#(
  parameter int DVC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_empty,
  input  logic [1:0]       head_kind,
  input  logic [2:0]       route_in,
  input  logic             va_win,
  input  logic [DVC_W-1:0] va_vc,
  input  logic             sa_win,
  output logic [2:0]       route_q,
  output logic [DVC_W-1:0] dvc_q,
  output logic             va_want,
  output logic             sa_want,
  output logic             pop
);

  vc_stage_e        stage_q, stage_nxt;
  logic             route_en, dvc_en;
  logic [2:0]       route_nxt;
  logic [DVC_W-1:0] dvc_nxt;
  logic             orphan;

  assign orphan  = (stage_q == VS_IDLE) && !fifo_empty && (head_kind == FT_BODY);
  assign va_want = (stage_q == VS_VCALLOC);
  assign sa_want = (stage_q == VS_SWALLOC) && !fifo_empty;
  assign pop     = sa_win || orphan;

  always_comb begin
    stage_nxt = stage_q;
    route_en  = 1'b0;
    dvc_en    = 1'b0;
    route_nxt = route_q;
    dvc_nxt   = dvc_q;
    case (stage_q)
      VS_IDLE: begin
        if (!fifo_empty && head_kind != FT_BODY) stage_nxt = VS_ROUTE;
      end
      VS_ROUTE: begin
        stage_nxt = VS_VCALLOC;
        route_en  = 1'b1;
        route_nxt = route_in;
      end
      VS_VCALLOC: begin
        if (va_win) begin
          stage_nxt = VS_SWALLOC;
          dvc_en    = 1'b1;
          dvc_nxt   = va_vc;
        end
      end
      VS_SWALLOC: begin
        if (sa_win && head_kind == FT_TAIL) stage_nxt = VS_IDLE;
      end
      default: stage_nxt = VS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= VS_IDLE;
    else        stage_q <= stage_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        route_q <= '0;
    else if (route_en) route_q <= route_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dvc_q <= '0;
    else if (dvc_en) dvc_q <= dvc_nxt;
  end

  // R5: a denied flit keeps its place at the front of the buffer
  p_sa_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == VS_SWALLOC && !fifo_empty && !sa_win)
      |=> (stage_q == VS_SWALLOC && !fifo_empty && $stable(head_kind)));

  // R6: route and downstream VC stay fixed while the packet is open
  p_route_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == VS_SWALLOC) |=> (stage_q == VS_IDLE || ($stable(route_q) && $stable(dvc_q))));

  // R1: VC allocation is entered only from route computation
  p_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q != VS_ROUTE && stage_q != VS_VCALLOC) |=> (stage_q != VS_VCALLOC));

endmodule

// File: rtl/vcr_input_port.sv
module vcr_input_port
  import vcr_pkg::*;
#(
  parameter int NUM_VC    = 4,
  parameter int BUF_DEPTH = 4,
  parameter int NUM_DVC   = 4,
  parameter int DATA_W    = 16,
  parameter int COORD_W   = 3,
  parameter int X_POS     = 1,
  parameter int Y_POS     = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 in_type,
  input  logic [$clog2(NUM_VC)-1:0]  in_vc,
  input  logic [DATA_W-1:0]          in_data,
  output logic [NUM_VC-1:0]          vc_full,
  output logic                       va_req,
  output logic [2:0]                 va_port,
  input  logic                       va_gnt,
  input  logic [$clog2(NUM_DVC)-1:0] va_gnt_vc,
  output logic                       sa_req,
  output logic [2:0]                 sa_port,
  input  logic                       sa_gnt,
  output logic                       st_valid,
  output logic [1:0]                 st_type,
  output logic [2:0]                 st_port,
  output logic [$clog2(NUM_DVC)-1:0] st_vc,
  output logic [DATA_W-1:0]          st_data,
  output logic                       rel_valid,
  output logic [2:0]                 rel_port,
  output logic [$clog2(NUM_DVC)-1:0] rel_vc
);

  localparam int VC_W   = $clog2(NUM_VC);
  localparam int DVC_W  = $clog2(NUM_DVC);
  localparam int FLIT_W = 2 + DATA_W;

  // reset: asserted at once, released after two clock edges
  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [FLIT_W-1:0] head_flit [NUM_VC];
  logic [2:0]        route_c   [NUM_VC];
  logic [2:0]        route_q   [NUM_VC];
  logic [DVC_W-1:0]  dvc_q     [NUM_VC];
  logic [NUM_VC-1:0] fifo_empty, fifo_full, pop_vec;
  logic [NUM_VC-1:0] va_want, sa_want, va_pick, sa_pick;
  logic [NUM_VC-1:0] va_win, sa_win;
  logic              flit_in;

  assign flit_in = (in_type != FT_IDLE);
  assign va_win  = va_pick & {NUM_VC{va_gnt}};
  assign sa_win  = sa_pick & {NUM_VC{sa_gnt}};

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic push;
    assign push = flit_in && (in_vc == VC_W'(v));

    vcr_flit_fifo #(
      .WIDTH(FLIT_W),
      .DEPTH(BUF_DEPTH)
    ) u_fifo (
      .clk      (clk),
      .rst_n    (rst_sync),
      .push     (push),
      .push_data({in_type, in_data}),
      .pop      (pop_vec[v]),
      .head     (head_flit[v]),
      .empty    (fifo_empty[v]),
      .full     (fifo_full[v])
    );

    vcr_route_xy #(
      .COORD_W(COORD_W),
      .X_POS  (X_POS),
      .Y_POS  (Y_POS)
    ) u_route (
      .dest(head_flit[v][2*COORD_W-1:0]),
      .port(route_c[v])
    );

    vcr_vc_ctrl #(
      .DVC_W(DVC_W)
    ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_sync),
      .fifo_empty(fifo_empty[v]),
      .head_kind (head_flit[v][FLIT_W-1 -: 2]),
      .route_in  (route_c[v]),
      .va_win    (va_win[v]),
      .va_vc     (va_gnt_vc),
      .sa_win    (sa_win[v]),
      .route_q   (route_q[v]),
      .dvc_q     (dvc_q[v]),
      .va_want   (va_want[v]),
      .sa_want   (sa_want[v]),
      .pop       (pop_vec[v])
    );
  end

  vcr_rr_arb #(.N(NUM_VC)) u_va_arb (
    .clk  (clk),
    .rst_n(rst_sync),
    .req  (va_want),
    .gnt  (va_pick)
  );

  vcr_rr_arb #(.N(NUM_VC)) u_sa_arb (
    .clk  (clk),
    .rst_n(rst_sync),
    .req  (sa_want),
    .gnt  (sa_pick)
  );

  // selection of the presenting VC for each allocator
  logic [1:0]        sel_kind;
  logic [DATA_W-1:0] sel_data;
  logic [DVC_W-1:0]  sel_dvc;
  logic [2:0]        sel_port, va_port_c;

  always_comb begin
    sel_kind  = '0;
    sel_data  = '0;
    sel_dvc   = '0;
    sel_port  = '0;
    va_port_c = '0;
    for (int v = 0; v < NUM_VC; v++) begin
      if (sa_pick[v]) begin
        sel_kind = head_flit[v][FLIT_W-1 -: 2];
        sel_data = head_flit[v][DATA_W-1:0];
        sel_dvc  = dvc_q[v];
        sel_port = route_q[v];
      end
      if (va_pick[v]) va_port_c = route_q[v];
    end
  end

  assign va_req  = |va_pick;
  assign va_port = va_port_c;
  assign sa_req  = |sa_pick;
  assign sa_port = sel_port;
  assign vc_full = fifo_full;

  // switch traversal register
  logic              fire, tail_fire;
  logic              st_valid_q, st_valid_nxt, rel_valid_q, rel_valid_nxt;
  logic [1:0]        st_type_q;
  logic [2:0]        st_port_q, rel_port_q;
  logic [DVC_W-1:0]  st_vc_q, rel_vc_q;
  logic [DATA_W-1:0] st_data_q;

  always_comb begin
    fire          = sa_req && sa_gnt;
    tail_fire     = fire && (sel_kind == FT_TAIL);
    st_valid_nxt  = fire;
    rel_valid_nxt = tail_fire;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      st_valid_q  <= 1'b0;
      rel_valid_q <= 1'b0;
    end else begin
      st_valid_q  <= st_valid_nxt;
      rel_valid_q <= rel_valid_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      st_type_q <= '0;
      st_port_q <= '0;
      st_vc_q   <= '0;
      st_data_q <= '0;
    end else if (fire) begin
      st_type_q <= sel_kind;
      st_port_q <= sel_port;
      st_vc_q   <= sel_dvc;
      st_data_q <= sel_data;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      rel_port_q <= '0;
      rel_vc_q   <= '0;
    end else if (tail_fire) begin
      rel_port_q <= sel_port;
      rel_vc_q   <= sel_dvc;
    end
  end

  assign st_valid  = st_valid_q;
  assign st_type   = st_type_q;
  assign st_port   = st_port_q;
  assign st_vc     = st_vc_q;
  assign st_data   = st_data_q;
  assign rel_valid = rel_valid_q;
  assign rel_port  = rel_port_q;
  assign rel_vc    = rel_vc_q;

  // R7: release only together with a departing tail
  p_rel_tail_r7: assert property (@(posedge clk) disable iff (!rst_sync)
    rel_valid |-> (st_valid && st_type == FT_TAIL && rel_vc == st_vc && rel_port == st_port));

  // R2: every departure follows a switch grant one edge earlier
  p_st_after_gnt_r2: assert property (@(posedge clk) disable iff (!rst_sync)
    st_valid |-> $past(sa_req && sa_gnt));

  // R13: a single VC wins the switch per cycle
  p_one_winner_r13: assert property (@(posedge clk) disable iff (!rst_sync)
    $onehot0(sa_win) && $onehot0(va_win));

endmodule

// File: tb/vcr_input_port_tb.sv
module vcr_input_port_tb;

  localparam int NVC = 4, DEP = 4, NDVC = 4, DW = 16, CW = 3, XP = 2, YP = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    in_type;
  logic [1:0]    in_vc;
  logic [DW-1:0] in_data;
  logic [NVC-1:0] vc_full;
  logic          va_req, va_gnt, sa_req, sa_gnt;
  logic [2:0]    va_port, sa_port, st_port, rel_port;
  logic [1:0]    va_gnt_vc, st_vc, rel_vc, st_type;
  logic          st_valid, rel_valid;
  logic [DW-1:0] st_data;

  // allocator models
  logic       va_en = 1'b1, sa_en = 1'b1;
  logic [2:0] sa_block = 3'd7;
  logic [1:0] dvc_sel = 2'd0;
  assign va_gnt    = va_req && va_en;
  assign va_gnt_vc = dvc_sel;
  assign sa_gnt    = sa_req && sa_en && (sa_port != sa_block);

  always #4 clk = ~clk;

  vcr_input_port #(
    .NUM_VC(NVC), .BUF_DEPTH(DEP), .NUM_DVC(NDVC), .DATA_W(DW),
    .COORD_W(CW), .X_POS(XP), .Y_POS(YP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .in_type(in_type), .in_vc(in_vc), .in_data(in_data),
    .vc_full(vc_full), .va_req(va_req), .va_port(va_port), .va_gnt(va_gnt),
    .va_gnt_vc(va_gnt_vc), .sa_req(sa_req), .sa_port(sa_port), .sa_gnt(sa_gnt),
    .st_valid(st_valid), .st_type(st_type), .st_port(st_port), .st_vc(st_vc),
    .st_data(st_data), .rel_valid(rel_valid), .rel_port(rel_port), .rel_vc(rel_vc)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // departure log
  int lg_n = 0;
  int lg_type [512];
  int lg_port [512];
  int lg_vc   [512];
  int lg_data [512];
  int lg_cyc  [512];
  int lg_rel  [512];

  always @(negedge clk) begin
    if (st_valid && lg_n < 512) begin
      lg_type[lg_n] = st_type;
      lg_port[lg_n] = st_port;
      lg_vc[lg_n]   = st_vc;
      lg_data[lg_n] = st_data;
      lg_cyc[lg_n]  = cyc;
      lg_rel[lg_n]  = (rel_valid && rel_vc == st_vc && rel_port == st_port) ? 1 : 0;
      lg_n = lg_n + 1;
    end
  end

  int n_chk = 0, n_fail = 0, last_push = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] k, input int vc, input logic [DW-1:0] d);
    in_type   = k;
    in_vc     = vc[1:0];
    in_data   = d;
    last_push = cyc + 1;
    @(negedge clk);
    in_type   = 2'b00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] dst(input int x, input int y);
    return {10'd0, 3'(y), 3'(x)};
  endfunction

  // route table: {x, y, expected port}; router sits at (2,5)
  localparam logic [8:0] RT_VEC [9] = '{
    {3'd2, 3'd5, 3'd0}, {3'd3, 3'd5, 3'd1}, {3'd7, 3'd0, 3'd1},
    {3'd0, 3'd7, 3'd2}, {3'd1, 3'd5, 3'd2}, {3'd2, 3'd6, 3'd3},
    {3'd2, 3'd7, 3'd3}, {3'd2, 3'd0, 3'd4}, {3'd2, 3'd4, 3'd4}
  };

  initial begin
    int base, t0, k, cnt_n, cnt_e;
    rst_n = 1'b0; in_type = 2'b00; in_vc = '0; in_data = '0;
    idle(3);
    // R14: quiet while in reset
    chk("R14 st_valid in reset", st_valid, 0);
    chk("R14 va_req in reset", va_req, 0);
    chk("R14 sa_req in reset", sa_req, 0);
    chk("R14 vc_full in reset", vc_full, 0);
    rst_n = 1'b1;
    idle(4);
    chk("R14 rel_valid after reset", rel_valid, 0);

    // table walk: single-flit packets (R4, R9, R1, R6, R7)
    for (int i = 0; i < 9; i++) begin
      base    = lg_n;
      dvc_sel = 2'(i % NDVC);
      send(2'b11, i % NVC, dst(RT_VEC[i][8:6], RT_VEC[i][5:3]));
      t0 = last_push;
      idle(6);
      chk("R9 single flit departs once", lg_n, base + 1);
      chk("R4 route port", lg_port[base], RT_VEC[i][2:0]);
      chk("R1 four-stage latency", lg_cyc[base], t0 + 4);
      chk("R7 release with tail", lg_rel[base], 1);
      chk("R6 downstream vc", lg_vc[base], i % NDVC);
    end

    // multi-flit packet back to back (R1, R2, R6, R7)
    base = lg_n; dvc_sel = 2'd2;
    send(2'b01, 1, dst(5, 5));
    t0 = last_push;
    send(2'b10, 1, 16'hB001);
    send(2'b10, 1, 16'hB002);
    send(2'b11, 1, 16'hB003);
    idle(8);
    chk("R2 four flits out", lg_n, base + 4);
    for (int j = 0; j < 4; j++) begin
      chk("R2 consecutive departure", lg_cyc[base + j], t0 + 4 + j);
      chk("R6 route on every flit", lg_port[base + j], 1);
      chk("R6 vc on every flit", lg_vc[base + j], 2);
      chk("R7 release only on tail", lg_rel[base + j], (j == 3) ? 1 : 0);
    end
    chk("R2 body payload", lg_data[base + 2], 16'hB002);

    // VC allocation withheld (R3)
    base = lg_n; dvc_sel = 2'd1; va_en = 1'b0;
    send(2'b01, 2, dst(2, 7));
    idle(5);
    chk("R3 va_req held", va_req, 1);
    chk("R3 va_port is route", va_port, 3);
    chk("R3 no switch request", sa_req, 0);
    chk("R3 nothing departs", lg_n, base);
    k = cyc; va_en = 1'b1;
    idle(4);
    chk("R3 head after grant", lg_cyc[base], k + 2);
    send(2'b11, 2, 16'h0);
    idle(4);
    chk("R3 tail releases vc", lg_vc[base + 1], 1);

    // switch allocation withheld (R5)
    base = lg_n; sa_en = 1'b0;
    send(2'b01, 3, dst(2, 0));
    send(2'b10, 3, 16'hC0DE);
    idle(8);
    chk("R5 sa_req retried", sa_req, 1);
    chk("R5 sa_port kept", sa_port, 4);
    chk("R5 nothing departs", lg_n, base);
    k = cyc; sa_en = 1'b1;
    idle(4);
    chk("R5 head after grant", lg_cyc[base], k + 1);
    chk("R5 body follows", lg_cyc[base + 1], k + 2);
    send(2'b11, 3, 16'h0);
    idle(4);
    chk("R5 tail closes packet", lg_rel[base + 2], 1);

    // head behind tail in the same VC (R8)
    base = lg_n; dvc_sel = 2'd3;
    send(2'b01, 0, dst(3, 5));
    t0 = last_push;
    send(2'b11, 0, 16'h0);
    send(2'b01, 0, dst(0, 5));
    send(2'b11, 0, 16'h0);
    idle(14);
    chk("R8 tail A time", lg_cyc[base + 1], t0 + 5);
    chk("R8 head B waits for tail", lg_cyc[base + 2], lg_cyc[base + 1] + 4);
    chk("R8 head B route", lg_port[base + 2], 2);

    // orphan body at idle VC (R10)
    base = lg_n;
    send(2'b10, 1, 16'hDEAD);
    t0 = last_push;
    send(2'b01, 1, dst(2, 6));
    send(2'b11, 1, 16'h0);
    idle(12);
    chk("R10 body dropped", lg_n, base + 2);
    chk("R10 first out is head", lg_type[base], 1);
    chk("R10 head timing", lg_cyc[base], t0 + 5);

    // idle kind writes nothing (R11)
    base = lg_n;
    in_type = 2'b00; in_vc = 2'd2; in_data = dst(3, 5);
    idle(6);
    chk("R11 no output from idle", lg_n, base);
    send(2'b11, 2, dst(3, 5));
    idle(6);
    chk("R11 only real flit departs", lg_n, base + 1);

    // full flag (R12)
    base = lg_n; sa_en = 1'b0;
    send(2'b01, 0, dst(3, 5));
    send(2'b10, 0, 16'h1);
    send(2'b10, 0, 16'h2);
    chk("R12 not full at three", vc_full, 0);
    send(2'b11, 0, 16'h3);
    chk("R12 full at depth", vc_full, 4'b0001);
    sa_en = 1'b1;
    idle(8);
    chk("R12 drained", vc_full, 0);
    chk("R12 all flits out", lg_n, base + 4);

    // VC independence (R13)
    base = lg_n; sa_block = 3'd1;
    send(2'b01, 0, dst(4, 5));
    send(2'b11, 0, 16'h0);
    send(2'b11, 1, dst(2, 7));
    idle(12);
    cnt_n = 0; cnt_e = 0;
    for (int j = base; j < lg_n; j++) begin
      if (lg_port[j] == 3) cnt_n++;
      if (lg_port[j] == 1) cnt_e++;
    end
    chk("R13 other VC passes", cnt_n, 1);
    chk("R13 blocked VC held", cnt_e, 0);
    sa_block = 3'd7;
    idle(8);
    chk("R13 blocked VC drains", lg_n, base + 3);

    // reset discards queued flits (R14)
    base = lg_n; sa_en = 1'b0;
    send(2'b01, 1, dst(2, 6));
    idle(5);
    rst_n = 1'b0;
    idle(2);
    chk("R14 sa_req cleared", sa_req, 0);
    rst_n = 1'b1;
    idle(4);
    sa_en = 1'b1;
    idle(8);
    chk("R14 queued flit dropped", lg_n, base);
    chk("R14 no va request", va_req, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule